// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port Controller

This block is one general-purpose I/O port with six pins. A CPU reaches it through a small register bus with a 2-bit select. Behind that select sit three 8-bit registers. The output data register holds the level that each output pin drives. The direction register holds one bit per pin, where 1 makes the pin an output. The port register is read-only and returns a per-bit mix: the latched output level for output pins and the synchronized pin level for input pins. The block drives one output-enable and one output-value line per pin, and it samples each pin input through a two-flop synchronizer.

Two low-power controls change how state is kept. Hardware standby clears the data and direction registers in the same way a reset does, which turns every pin back into an input. Software standby freezes everything: register writes are dropped, the pins keep driving their last values, and the port register view holds the last value it showed before standby began.

A configuration parameter selects a reduced-pin build. In that build the two highest pin bits are reserved, as the top two bits of every register always are. Reserved bits ignore writes and read back as a fixed don't-care value of 0.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a system reset the data and direction registers read 0x00, `pin_oe` is all zero and `pin_out` is all zero.
- R2: A bus write with select 0 (data register) and `wr_en` high loads `wr_data[5:0]` at that clock edge. From the next cycle the data register reads back that value and `pin_out` carries it.
- R3: Every pin whose direction bit is 1 has `pin_oe` high, and every pin whose direction bit is 0 has `pin_oe` low. Select 1 addresses the direction register. `pin_out[i]` always carries data register bit i.
- R4: Register bits 7 and 6 are reserved. Writing them changes nothing, and they read as 0 in every register.
- R5: A read with select 2 (port register) returns, for each bit i, the data register bit when direction bit i is 1 and the synchronized pin level when direction bit i is 0.
- R6: A change on `pin_in` shows up in the port register read after exactly two rising clock edges and not after one.
- R7: A write with select 2 has no effect on the data register, the direction register, `pin_oe` or `pin_out`.
- R8: A clock edge with `hw_stby` high clears the data and direction registers, and this clear wins over a write in the same cycle. Afterwards the port register read returns the pin levels.
- R9: While `sw_stby` is high, writes are ignored, and the data and direction registers, `pin_oe` and `pin_out` all keep their values.
- R10: While `sw_stby` is high, the port register read returns the value it had at the last edge before standby, whatever the pins do. After standby ends it follows the pins again.
- R11: With `REDUCED=1`, bits 5 and 4 are also reserved. Writes to them are ignored, they read as 0, and `pin_oe`/`pin_out` for those pins stay 0.
- R12: `rd_data` is 0x00 whenever `rd_en` is low. Select 3 is unused: a read of it returns 0x00 and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hw_stby | input | 1 | Hardware standby: clears data and direction registers |
| sw_stby | input | 1 | Software standby: freezes registers and the port view |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 port, 3 unused |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, read data valid in the same cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| pin_in | input | 6 | Pin input levels (asynchronous) |
| pin_oe | output | 6 | Per-pin output enable |
| pin_out | output | 6 | Per-pin output value |

## Verification
The bench builds mixed direction patterns so that one port read has to combine latched and live bits. A design that muxed the whole byte on a single direction bit, or that swapped the two sources, would return the wrong mix. It counts the edges from a pin change to its appearance in the read, so a synchronizer one stage too short or too long misses the exact cycle. A write in the same cycle as hardware standby checks that the clear has priority. A write attempt and pin activity during software standby check that a design which kept tracking the pins, or kept accepting writes, is caught. Writes to reserved bits, to the port register and to the unused select are each checked against the pins and the read-back, and a second instance in the reduced build checks that bits 5 and 4 stay at 0.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants, select encoding and mask helper for the GPIO port.
// Assumes registers are REG_W bits wide and pins occupy the low bits.
package gpio_port_pkg;

    localparam int REG_W = 8;

    // Register select codes on the bus
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PORT = 2'd2,
        SEL_NONE = 2'd3
    } gpio_sel_e;

    // Mask of implemented pin bits; reduced build drops the top two pins
    function automatic logic [REG_W-1:0] impl_mask(input int num_pins, input bit reduced);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < num_pins; i++) begin
            if (!(reduced && (i >= num_pins - 2))) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: multi-stage synchronizer for the pin inputs.
// Assumes each bit is treated independently; no bus coherence is implied.
// Reset clears every stage to 0.
module gpio_pin_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw pin level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages: shift the previous stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: output data and direction registers, one flop pair per implemented bit.
// Assumes hardware standby has priority over software standby and writes.
// Reserved bits (mask bit 0) have no storage and read as 0.
module gpio_ctrl_regs #(
    parameter int           W         = 6,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic         data_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q
);

    logic unused_rsvd_wdata;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (IMPL_MASK[i]) begin : g_impl
                logic data_bit;
                logic dir_bit;

                // Data bit: clear on reset or hw standby, hold in sw standby
                always_ff @(posedge clk) begin
                    if (!rst_n)                   data_bit <= 1'b0;
                    else if (hw_stby)             data_bit <= 1'b0;
                    else if (!sw_stby && data_we) data_bit <= wdata[i];
                end

                // Direction bit: same clear and hold rules as the data bit
                always_ff @(posedge clk) begin
                    if (!rst_n)                  dir_bit <= 1'b0;
                    else if (hw_stby)            dir_bit <= 1'b0;
                    else if (!sw_stby && dir_we) dir_bit <= wdata[i];
                end

                assign data_q[i] = data_bit;
                assign dir_q[i]  = dir_bit;
            end else begin : g_rsvd
                assign data_q[i] = 1'b0;
                assign dir_q[i]  = 1'b0;
            end
        end
    endgenerate

    assign unused_rsvd_wdata = ^(wdata & ~IMPL_MASK);

endmodule

// File: rtl/gpio_port_view.sv
// Module: port register view, a per-bit mix of latched output and synced pin.
// Assumes pin_sync is already synchronous to clk. During software standby the
// view returned is the one captured at the last edge before standby.
module gpio_port_view #(
    parameter int           W         = 6,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_stby,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] view
);

    logic [W-1:0] live;
    logic [W-1:0] held_q;

    // Per-bit source choice: output pins show data, input pins show the pin
    always_comb begin
        for (int b = 0; b < W; b++) begin
            live[b] = IMPL_MASK[b] & (dir_q[b] ? data_q[b] : pin_sync[b]);
        end
    end

    // Snapshot register: follows the live view except in software standby
    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= '0;
        else if (!sw_stby) held_q <= live;
    end

    // Output selection: frozen snapshot in standby, live view otherwise
    always_comb begin
        view = sw_stby ? held_q : live;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: top of the six-pin GPIO port controller.
// Decodes the register bus, holds data and direction registers, synchronizes
// the pins and returns combinational read data in the cycle of rd_en.
// Assumes wr_en and rd_en are not both used to reach a register in one cycle.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter bit REDUCED     = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_stby,
    input  logic                sw_stby,
    input  logic [1:0]          reg_sel,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);

    localparam int                 RSVD_W = REG_W - NUM_PINS;
    localparam logic [REG_W-1:0]   MASK_W = impl_mask(NUM_PINS, REDUCED);
    localparam logic [NUM_PINS-1:0] MASK  = MASK_W[NUM_PINS-1:0];

    gpio_sel_e           sel;
    logic                data_we;
    logic                dir_we;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] view;
    logic [NUM_PINS-1:0] rd_field;
    logic                unused_rsvd_bus;

    // Bus decode: map select code to a write strobe per register
    always_comb begin
        sel     = gpio_sel_e'(reg_sel);
        data_we = wr_en && (sel == SEL_DATA);
        dir_we  = wr_en && (sel == SEL_DIR);
    end

    gpio_ctrl_regs #(
        .W         (NUM_PINS),
        .IMPL_MASK (MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .data_we (data_we),
        .dir_we  (dir_we),
        .wdata   (wr_data[NUM_PINS-1:0]),
        .data_q  (data_q),
        .dir_q   (dir_q)
    );

    gpio_pin_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_port_view #(
        .W         (NUM_PINS),
        .IMPL_MASK (MASK)
    ) u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_stby  (sw_stby),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .pin_sync (pin_sync),
        .view     (view)
    );

    // Read mux: choose the addressed register, zero when not reading
    always_comb begin
        rd_field = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA: rd_field = data_q;
                SEL_DIR:  rd_field = dir_q;
                SEL_PORT: rd_field = view;
                default:  rd_field = '0;
            endcase
        end
        rd_data = {{RSVD_W{1'b0}}, rd_field};
    end

    // Pin drive: direction gives the enable, data gives the level
    always_comb begin
        pin_oe  = dir_q;
        pin_out = data_q;
    end

    assign unused_rsvd_bus = ^wr_data[REG_W-1:NUM_PINS];

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
// Checker: temporal properties of the GPIO port seen at its ports.
// Attached to every instance of gpio_port_ctrl by the bind below.
module gpio_port_ctrl_chk #(
    parameter int NUM_PINS = 6,
    parameter bit REDUCED  = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hw_stby,
    input logic                sw_stby,
    input logic [1:0]          reg_sel,
    input logic                wr_en,
    input logic                rd_en,
    input logic [7:0]          wr_data,
    input logic [7:0]          rd_data,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out
);

    localparam logic [7:0] MASK_W = gpio_port_pkg::impl_mask(NUM_PINS, REDUCED);
    localparam logic [NUM_PINS-1:0] MASK = MASK_W[NUM_PINS-1:0];

    // R1: first cycle out of reset has every pin idle
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0) && (pin_out == '0));

    // R2: a data write shows on pin_out in the next cycle
    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && reg_sel == 2'd0 && !sw_stby && !hw_stby)
        |-> pin_out == ($past(wr_data[NUM_PINS-1:0]) & MASK));

    // R7: writes to the port register leave the pins alone
    assert_port_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && reg_sel == 2'd2 && !hw_stby) |-> $stable(pin_oe) && $stable(pin_out));

    // R8: hardware standby leaves every pin undriven and low
    assert_hw_stby_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hw_stby) |-> (pin_oe == '0) && (pin_out == '0));

    // R9: software standby freezes pin drive
    assert_sw_stby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_stby && !hw_stby) |-> $stable(pin_oe) && $stable(pin_out));

    // R10: port view read twice in standby returns the same value
    assert_view_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 2'd2 && sw_stby && !hw_stby)
        && $past(rd_en && reg_sel == 2'd2 && sw_stby && !hw_stby)
        |-> $stable(rd_data));

    // R12: idle read bus is zero
    assert_rd_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == 8'h00);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .REDUCED  (REDUCED)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .sw_stby (sw_stby),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] rd_data_r;
    logic [5:0] pin_in = 6'h00;
    logic [5:0] pin_oe, pin_out, pin_oe_r, pin_out_r;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    gpio_port_ctrl #(.REDUCED(1'b1)) uut_red (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data_r), .pin_in(pin_in), .pin_oe(pin_oe_r), .pin_out(pin_out_r)
    );

    // Vector: op[25:24] (0 write, 1 read), sel[23:22], wdata[21:14], pins[13:8], exp[7:0]
    localparam int NV = 13;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 2'd1, 8'h0F, 6'h00, 8'h00},
        {2'd0, 2'd0, 8'h0A, 6'h00, 8'h00},
        {2'd1, 2'd2, 8'h00, 6'h35, 8'h3A},
        {2'd1, 2'd0, 8'h00, 6'h35, 8'h0A},
        {2'd1, 2'd1, 8'h00, 6'h35, 8'h0F},
        {2'd0, 2'd0, 8'hFF, 6'h35, 8'h00},
        {2'd1, 2'd0, 8'h00, 6'h35, 8'h3F},
        {2'd1, 2'd2, 8'h00, 6'h00, 8'h0F},
        {2'd0, 2'd1, 8'hC0, 6'h00, 8'h00},
        {2'd1, 2'd1, 8'h00, 6'h00, 8'h00},
        {2'd1, 2'd2, 8'h00, 6'h2A, 8'h2A},
        {2'd0, 2'd2, 8'h00, 6'h2A, 8'h00},
        {2'd1, 2'd0, 8'h00, 6'h2A, 8'h3F}
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v, output logic [7:0] vr);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1;
        v = rd_data; vr = rd_data_r;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [7:0] v, vr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v, vr); check("R1", "data after reset", v, 8'h00);
        rd(2'd1, v, vr); check("R1", "dir after reset", v, 8'h00);
        check("R1", "pin_oe after reset", {2'b00, pin_oe}, 8'h00);
        check("R1", "pin_out after reset", {2'b00, pin_out}, 8'h00);

        // Table walk: R2 for data/dir reads, R5 for port reads
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            pin_in = VEC[k][13:8];
            if (VEC[k][25:24] == 2'd0) begin
                wr(VEC[k][23:22], VEC[k][21:14]);
            end else begin
                settle();
                rd(VEC[k][23:22], v, vr);
                check(VEC[k][23:22] == 2'd2 ? "R5" : "R2", "table read", v, VEC[k][7:0]);
            end
        end

        // R4: reserved bits 7,6 ignored, read as 0
        wr(2'd0, 8'hC0);
        rd(2'd0, v, vr); check("R4", "data after reserved-only write", v, 8'h00);
        check("R4", "pin_out after reserved-only write", {2'b00, pin_out}, 8'h00);

        // R3: direction gives enable, data gives level
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h07);
        check("R3", "pin_oe from dir", {2'b00, pin_oe}, 8'h05);
        check("R3", "pin_out from data", {2'b00, pin_out}, 8'h07);

        // R7: write to port register ignored
        wr(2'd2, 8'h3A);
        check("R7", "pin_oe after port write", {2'b00, pin_oe}, 8'h05);
        check("R7", "pin_out after port write", {2'b00, pin_out}, 8'h07);
        rd(2'd0, v, vr); check("R7", "data after port write", v, 8'h07);

        // R12: unused select and idle bus
        wr(2'd3, 8'hFF);
        rd(2'd3, v, vr); check("R12", "unused select read", v, 8'h00);
        rd(2'd1, v, vr); check("R12", "dir after unused write", v, 8'h05);
        #1; check("R12", "rd_data with rd_en low", rd_data, 8'h00);

        // R6: two-stage latency on an input pin (dir=0 on all pins)
        wr(2'd1, 8'h00);
        pin_in = 6'h00;
        settle();
        pin_in = 6'h21;
        rd(2'd2, v, vr); check("R6", "port after one edge", v, 8'h00);
        rd(2'd2, v, vr); check("R6", "port after two edges", v, 8'h21);

        // R8: hw standby clears, wins over a same-cycle write
        wr(2'd1, 8'h3F);
        wr(2'd0, 8'h15);
        @(negedge clk);
        hw_stby = 1'b1; reg_sel = 2'd0; wr_data = 8'h3F; wr_en = 1'b1;
        @(negedge clk);
        hw_stby = 1'b0; wr_en = 1'b0;
        rd(2'd0, v, vr); check("R8", "data after hw standby", v, 8'h00);
        rd(2'd1, v, vr); check("R8", "dir after hw standby", v, 8'h00);
        check("R8", "pin_oe after hw standby", {2'b00, pin_oe}, 8'h00);
        rd(2'd2, v, vr); check("R8", "port shows pins", v, 8'h21);

        // R9/R10: software standby freezes registers and view
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h01);
        pin_in = 6'h3C;
        settle();
        rd(2'd2, v, vr); check("R10", "port before sw standby", v, 8'h3D);
        @(negedge clk);
        sw_stby = 1'b1; reg_sel = 2'd0; wr_data = 8'h02; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pin_in = 6'h00;
        settle();
        rd(2'd2, v, vr); check("R10", "port frozen in sw standby", v, 8'h3D);
        rd(2'd0, v, vr); check("R9", "data held in sw standby", v, 8'h01);
        check("R9", "pin_out held", {2'b00, pin_out}, 8'h01);
        check("R9", "pin_oe held", {2'b00, pin_oe}, 8'h03);
        @(negedge clk);
        sw_stby = 1'b0;
        settle();
        rd(2'd2, v, vr); check("R10", "port tracks after sw standby", v, 8'h01);

        // R11: reduced build drops bits 5 and 4
        wr(2'd1, 8'h3F);
        wr(2'd0, 8'h3F);
        rd(2'd0, v, vr); check("R11", "reduced data read", vr, 8'h0F);
        check("R11", "full data read", v, 8'h3F);
        check("R11", "reduced pin_oe", {2'b00, pin_oe_r}, 8'h0F);
        check("R11", "reduced pin_out", {2'b00, pin_out_r}, 8'h0F);
        wr(2'd1, 8'h00);
        pin_in = 6'h3F;
        settle();
        rd(2'd2, v, vr); check("R11", "reduced port read", vr, 8'h0F);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule